// File: doc/BRIEF.md
# CAN Receive Acceptance Filter with Buffer Rollover

This block sits behind a CAN bit-level receiver and decides, for every completed standard-format frame, whether the frame is wanted and where it is kept. Six programmable identifier filters are split into two groups. Filters 0 and 1 share the first mask and deliver into receive buffer 0. Filters 2 to 5 share the second mask and deliver into receive buffer 1. A frame that lands in a buffer sets that buffer's full flag and pulses its receive interrupt. The buffer keeps the identifier, remote-request flag, eight data bytes and the index of the filter that accepted the frame. The buffer is held until the host releases it.

Filters, masks and a control byte are loaded through a write-only byte port. When the rollover option is on, a frame meant for an occupied buffer 0 moves on into buffer 1. A frame that finds no free target is dropped and raises a sticky overflow error. The frame input is a single-cycle valid strobe with no ready signal. The block takes a frame on every cycle that carries the strobe and never applies back-pressure, so a frame with no room is lost and reported rather than stalled.

Top module: `can_accept_filter`

## Requirements
- R1: After reset all filter and mask registers are zero and rollover is off. Every buffer is empty, no interrupt is raised and the overflow error is clear. With zero masks, filter 0 accepts any identifier into buffer 0.
- R2: An identifier is held left-justified in two bytes. The high byte holds ID[10:3] and bits 7:5 of the low byte hold ID[2:0]. Bits 4:0 of the low byte have no effect. Filter n's high byte is at address 2n and its low byte at 2n+1. Mask 0 is at addresses 12/13, mask 1 at 14/15, and bit 0 of address 16 enables rollover.
- R3: A mask bit of 0 makes that identifier bit don't-care, and a filter hits when every masked bit equals the filter bit. A mask of FF/E0 needs all 11 bits to match, and FC/00 compares only ID[10:5]. A frame that hits no filter changes no buffer.
- R4: Filters 0 and 1 are compared under mask 0 and deliver to buffer 0. Filters 2 to 5 are compared under mask 1 and deliver to buffer 1.
- R5: When several filters hit, the lowest index wins: a group-0 hit beats any group-1 hit. The winning index is stored with the frame.
- R6: A delivered frame's identifier, remote flag and data appear on the buffer's outputs and its full flag is set in the cycle after the strobe. The buffer's interrupt is high for exactly that one cycle.
- R7: An accepted frame whose target buffer is full is dropped. The stored contents stay unchanged, and the overflow error is set and stays set until the overflow clear input, which loses to a new drop in the same cycle.
- R8: With rollover on, a group-0 frame that finds buffer 0 full goes to buffer 1 if buffer 1 is free, keeping its filter index. With rollover off, or with both buffers full, it is dropped (R7).
- R9: A buffer's clear input empties it. A clear in the same cycle as a strobe frees the buffer for that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write byte |
| frm_valid | input | 1 | One-cycle strobe: a received frame is present |
| frm_id | input | 11 | Standard identifier of the frame |
| frm_rtr | input | 1 | Remote-request flag of the frame |
| frm_data | input | 64 | Data bytes, byte 0 in bits 7:0 |
| buf_clr | input | 2 | Per-buffer release from the host |
| ovf_clr | input | 1 | Clears the overflow error |
| buf_full | output | 2 | Per-buffer occupied flag |
| rx_irq | output | 2 | Per-buffer one-cycle receive interrupt |
| buf_idx | output | 2x3 | Index of the filter that filled each buffer |
| buf_id | output | 2x11 | Stored identifier per buffer |
| buf_rtr | output | 2 | Stored remote flag per buffer |
| buf_data | output | 2x64 | Stored data per buffer |
| ovf_err | output | 1 | Sticky multiple-receive overflow error |

## Verification
The bench targets several boundary cases:
- An identifier that a group-1 filter accepts only because mask 1 ignores the low bits, while the fully-masked group-0 filter rejects it. A design that swapped the masks would deliver it to the wrong buffer or not at all.
- A frame that hits both groups. It must go to buffer 0 with the lower index; a priority error shows up as a wrong stored index.
- Overflow with rollover off and with rollover on. A design that overwrote a full buffer would show a changed stored identifier, and one that ignored rollover would leave buffer 1 empty.
- A clear arriving in the same cycle as a frame. If the clear were applied after the occupancy test, the frame would be lost and an overflow raised.

// File: rtl/can_acf_pkg.sv
package can_acf_pkg;
  localparam int ACF_ID_W    = 11;
  localparam int ACF_NFILT   = 6;
  localparam int ACF_NGRP0   = 2;
  localparam int ACF_NBYTES  = 8;
  localparam int ACF_NBUF    = 2;
  localparam int ACF_AW      = 5;

  typedef enum logic [0:0] {
    DEST_BUF0 = 1'b0,
    DEST_BUF1 = 1'b1
  } dest_e;
endpackage

// File: rtl/can_acf_regs.sv
module can_acf_regs
  import can_acf_pkg::*;
#(
  parameter int NFILT = ACF_NFILT,
  parameter int ID_W  = ACF_ID_W,
  parameter int AW    = ACF_AW
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [AW-1:0]                  addr,
  input  logic [7:0]                     wdata,
  output logic [NFILT-1:0][ID_W-1:0]     filt_id,
  output logic [1:0][ID_W-1:0]           mask_id,
  output logic                           roll_en
);
  localparam int LO_W      = ID_W - 8;
  localparam int MASK_BASE = 2 * NFILT;
  localparam int CTRL_ADDR = MASK_BASE + 4;

  // filter value registers, one pair per filter
  for (genvar i = 0; i < NFILT; i++) begin : g_filt
    logic [7:0]      hi_q;
    logic [LO_W-1:0] lo_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hi_q <= '0;
        lo_q <= '0;
      end else if (we) begin
        if (addr == AW'(2 * i))     hi_q <= wdata;
        if (addr == AW'(2 * i + 1)) lo_q <= wdata[7 -: LO_W];
      end
    end
    assign filt_id[i] = {hi_q, lo_q};
  end

  // shared mask registers, one per group
  for (genvar m = 0; m < 2; m++) begin : g_mask
    logic [7:0]      hi_q;
    logic [LO_W-1:0] lo_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hi_q <= '0;
        lo_q <= '0;
      end else if (we) begin
        if (addr == AW'(MASK_BASE + 2 * m))     hi_q <= wdata;
        if (addr == AW'(MASK_BASE + 2 * m + 1)) lo_q <= wdata[7 -: LO_W];
      end
    end
    assign mask_id[m] = {hi_q, lo_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                               roll_en <= 1'b0;
    else if (we && addr == AW'(CTRL_ADDR))    roll_en <= wdata[0];
  end
endmodule

// File: rtl/can_id_matcher.sv
module can_id_matcher
  import can_acf_pkg::*;
#(
  parameter int NFILT = ACF_NFILT,
  parameter int NGRP0 = ACF_NGRP0,
  parameter int ID_W  = ACF_ID_W,
  localparam int IDX_W = $clog2(NFILT)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ID_W-1:0]            id,
  input  logic [NFILT-1:0][ID_W-1:0] filt_id,
  input  logic [1:0][ID_W-1:0]       mask_id,
  output logic [NFILT-1:0]           hit,
  output logic                       g0_hit,
  output logic                       g1_hit,
  output logic [IDX_W-1:0]           g0_idx,
  output logic [IDX_W-1:0]           g1_idx
);
  // per-filter compare, mask chosen by group membership
  for (genvar i = 0; i < NFILT; i++) begin : g_cmp
    localparam int MSEL = (i < NGRP0) ? 0 : 1;
    assign hit[i] = ~|((id ^ filt_id[i]) & mask_id[MSEL]);
  end

  assign g0_hit = |hit[NGRP0-1:0];
  assign g1_hit = |hit[NFILT-1:NGRP0];

  // lowest-index priority within each group
  always_comb begin
    g0_idx = '0;
    for (int k = NGRP0 - 1; k >= 0; k--)
      if (hit[k]) g0_idx = IDX_W'(k);
    g1_idx = IDX_W'(NGRP0);
    for (int k = NFILT - 1; k >= NGRP0; k--)
      if (hit[k]) g1_idx = IDX_W'(k);
  end

  // R5: reported group index names a filter that actually hit
  p_idx_hits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    g0_hit |-> hit[g0_idx]);
endmodule

// File: rtl/can_rx_steer.sv
module can_rx_steer
  import can_acf_pkg::*;
#(
  parameter int NFILT = ACF_NFILT,
  localparam int IDX_W = $clog2(NFILT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_valid,
  input  logic             g0_hit,
  input  logic             g1_hit,
  input  logic [IDX_W-1:0] g0_idx,
  input  logic [IDX_W-1:0] g1_idx,
  input  logic             roll_en,
  input  logic [1:0]       full,
  input  logic [1:0]       clr,
  input  logic             err_clr,
  output logic [1:0]       load,
  output logic [IDX_W-1:0] load_idx,
  output logic             err
);
  logic [1:0] free_now;
  logic       drop;
  dest_e      dest;

  // a clear in the same cycle releases the buffer first
  assign free_now = ~full | clr;

  always_comb begin
    load     = 2'b00;
    drop     = 1'b0;
    dest     = DEST_BUF0;
    load_idx = g0_idx;
    if (frm_valid && g0_hit) begin
      if (free_now[0]) begin
        dest    = DEST_BUF0;
        load[0] = 1'b1;
      end else if (roll_en && free_now[1]) begin
        dest    = DEST_BUF1;
        load[1] = 1'b1;
      end else begin
        drop = 1'b1;
      end
    end else if (frm_valid && g1_hit) begin
      load_idx = g1_idx;
      dest     = DEST_BUF1;
      if (free_now[1]) load[1] = 1'b1;
      else             drop    = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err <= 1'b0;
    else        err <= (err & ~err_clr) | drop;
  end

  // R7: the overflow error is sticky until cleared
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err && !err_clr |=> err);
endmodule

// File: rtl/can_rx_slot.sv
module can_rx_slot
  import can_acf_pkg::*;
#(
  parameter int ID_W   = ACF_ID_W,
  parameter int NBYTES = ACF_NBYTES,
  parameter int IDX_W  = 3,
  localparam int DW    = 8 * NBYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             clr,
  input  logic [ID_W-1:0]  in_id,
  input  logic             in_rtr,
  input  logic [DW-1:0]    in_data,
  input  logic [IDX_W-1:0] in_idx,
  output logic             full,
  output logic             irq,
  output logic [ID_W-1:0]  q_id,
  output logic             q_rtr,
  output logic [DW-1:0]    q_data,
  output logic [IDX_W-1:0] q_idx
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      irq  <= 1'b0;
    end else begin
      irq <= load;
      if (load)     full <= 1'b1;
      else if (clr) full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_id   <= '0;
      q_rtr  <= 1'b0;
      q_data <= '0;
      q_idx  <= '0;
    end else if (load) begin
      q_id   <= in_id;
      q_rtr  <= in_rtr;
      q_data <= in_data;
      q_idx  <= in_idx;
    end
  end

  // R6: interrupt only accompanies an occupied buffer
  p_irq_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> full);
  // R9: only a clear may empty the buffer
  p_full_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    full && !clr |=> full);
  // R7: an occupied buffer keeps its contents unless released
  p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    full && !clr |=> $stable(q_id) && $stable(q_data));
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_acf_pkg::*;
#(
  parameter int NFILT  = ACF_NFILT,
  parameter int NGRP0  = ACF_NGRP0,
  parameter int ID_W   = ACF_ID_W,
  parameter int NBYTES = ACF_NBYTES,
  parameter int AW     = ACF_AW,
  localparam int IDX_W = $clog2(NFILT),
  localparam int DW    = 8 * NBYTES,
  localparam int NBUF  = ACF_NBUF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [AW-1:0]              cfg_addr,
  input  logic [7:0]                 cfg_wdata,
  input  logic                       frm_valid,
  input  logic [ID_W-1:0]            frm_id,
  input  logic                       frm_rtr,
  input  logic [DW-1:0]              frm_data,
  input  logic [NBUF-1:0]            buf_clr,
  input  logic                       ovf_clr,
  output logic [NBUF-1:0]            buf_full,
  output logic [NBUF-1:0]            rx_irq,
  output logic [NBUF-1:0][IDX_W-1:0] buf_idx,
  output logic [NBUF-1:0][ID_W-1:0]  buf_id,
  output logic [NBUF-1:0]            buf_rtr,
  output logic [NBUF-1:0][DW-1:0]    buf_data,
  output logic                       ovf_err
);
  logic [NFILT-1:0][ID_W-1:0] filt_id;
  logic [1:0][ID_W-1:0]       mask_id;
  logic                       roll_en;
  logic [NFILT-1:0]           hit;
  logic                       g0_hit, g1_hit;
  logic [IDX_W-1:0]           g0_idx, g1_idx, load_idx;
  logic [NBUF-1:0]            load;

  can_acf_regs #(.NFILT(NFILT), .ID_W(ID_W), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .filt_id(filt_id), .mask_id(mask_id), .roll_en(roll_en));

  can_id_matcher #(.NFILT(NFILT), .NGRP0(NGRP0), .ID_W(ID_W)) u_match (
    .clk(clk), .rst_n(rst_n), .id(frm_id), .filt_id(filt_id), .mask_id(mask_id),
    .hit(hit), .g0_hit(g0_hit), .g1_hit(g1_hit), .g0_idx(g0_idx), .g1_idx(g1_idx));

  can_rx_steer #(.NFILT(NFILT)) u_steer (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .g0_hit(g0_hit),
    .g1_hit(g1_hit), .g0_idx(g0_idx), .g1_idx(g1_idx), .roll_en(roll_en),
    .full(buf_full), .clr(buf_clr), .err_clr(ovf_clr), .load(load),
    .load_idx(load_idx), .err(ovf_err));

  for (genvar b = 0; b < NBUF; b++) begin : g_slot
    can_rx_slot #(.ID_W(ID_W), .NBYTES(NBYTES), .IDX_W(IDX_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .load(load[b]), .clr(buf_clr[b]),
      .in_id(frm_id), .in_rtr(frm_rtr), .in_data(frm_data), .in_idx(load_idx),
      .full(buf_full[b]), .irq(rx_irq[b]), .q_id(buf_id[b]), .q_rtr(buf_rtr[b]),
      .q_data(buf_data[b]), .q_idx(buf_idx[b]));
  end

  // R3: a frame that hits no filter raises no interrupt
  p_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && !(|hit) |=> rx_irq == '0);
  // R4: buffer 0 only ever holds frames from group-0 filters
  p_grp0_idx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq[0] |-> buf_idx[0] < IDX_W'(NGRP0));
  // R8: without rollover an overflowing group-0 frame never reaches buffer 1
  p_no_roll_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && g0_hit && buf_full[0] && !buf_clr[0] && !roll_en
    |=> !rx_irq[1] && ovf_err);
endmodule

// File: tb/tb_can_accept_filter.sv
module tb_can_accept_filter;
  logic             clk = 1'b0;
  logic             rst_n;
  logic             cfg_we;
  logic [4:0]       cfg_addr;
  logic [7:0]       cfg_wdata;
  logic             frm_valid;
  logic [10:0]      frm_id;
  logic             frm_rtr;
  logic [63:0]      frm_data;
  logic [1:0]       buf_clr;
  logic             ovf_clr;
  logic [1:0]       buf_full;
  logic [1:0]       rx_irq;
  logic [1:0][2:0]  buf_idx;
  logic [1:0][10:0] buf_id;
  logic [1:0]       buf_rtr;
  logic [1:0][63:0] buf_data;
  logic             ovf_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  can_accept_filter dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .frm_valid(frm_valid), .frm_id(frm_id),
    .frm_rtr(frm_rtr), .frm_data(frm_data), .buf_clr(buf_clr), .ovf_clr(ovf_clr),
    .buf_full(buf_full), .rx_irq(rx_irq), .buf_idx(buf_idx), .buf_id(buf_id),
    .buf_rtr(buf_rtr), .buf_data(buf_data), .ovf_err(ovf_err));

  // vector: {id[20:10], rtr[9], clr[8:7], errclr[6], exp_irq[5:4], exp_idx[3:1], exp_err[0]}
  localparam int NV = 13;
  localparam logic [20:0] VEC [NV] = '{
    {11'h123, 1'b0, 2'd3, 1'b1, 2'b01, 3'd0, 1'b0},  // R2 R3 exact match
    {11'h456, 1'b1, 2'd3, 1'b1, 2'b01, 3'd1, 1'b0},  // R4 filter 1, remote
    {11'h124, 1'b0, 2'd3, 1'b1, 2'b10, 3'd4, 1'b0},  // R3 R5 coarse mask only
    {11'h21F, 1'b0, 2'd3, 1'b1, 2'b10, 3'd2, 1'b0},  // R4
    {11'h3FF, 1'b0, 2'd3, 1'b1, 2'b10, 3'd3, 1'b0},
    {11'h7E5, 1'b1, 2'd3, 1'b1, 2'b10, 3'd5, 1'b0},
    {11'h000, 1'b0, 2'd3, 1'b1, 2'b00, 3'd0, 1'b0},  // R3 no hit
    {11'h457, 1'b0, 2'd3, 1'b1, 2'b00, 3'd0, 1'b0},  // R3 no hit
    {11'h123, 1'b0, 2'd0, 1'b0, 2'b01, 3'd0, 1'b0},
    {11'h456, 1'b0, 2'd0, 1'b0, 2'b00, 3'd0, 1'b1},  // R7 R8 overflow, rollover off
    {11'h21F, 1'b0, 2'd0, 1'b0, 2'b10, 3'd2, 1'b1},  // R7 error sticky
    {11'h3E0, 1'b0, 2'd0, 1'b0, 2'b00, 3'd0, 1'b1},  // R7 buffer 1 full
    {11'h3E0, 1'b0, 2'd2, 1'b1, 2'b10, 3'd3, 1'b0}   // R9 release buffer 1
  };

  function automatic logic [63:0] pat(input logic [10:0] id);
    return {8{id[7:0]}} ^ 64'h0123_4567_89AB_CDEF;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic release_bufs(input logic [1:0] c, input logic e);
    @(negedge clk);
    buf_clr = c; ovf_clr = e;
    @(negedge clk);
    buf_clr = 2'b00; ovf_clr = 1'b0;
  endtask

  // drive one frame; outputs are sampled at the following falling edge
  task automatic send(input logic [10:0] id, input logic rtr, input logic [1:0] c);
    @(negedge clk);
    frm_valid = 1'b1; frm_id = id; frm_rtr = rtr; frm_data = pat(id); buf_clr = c;
    @(negedge clk);
    frm_valid = 1'b0; buf_clr = 2'b00;
  endtask

  task automatic chk_buf(input string req, input int b, input logic [10:0] id,
                         input logic rtr, input logic [2:0] idx);
    chk(req, 64'(buf_id[b]), 64'(id));
    chk(req, 64'(buf_rtr[b]), 64'(rtr));
    chk(req, buf_data[b], pat(id));
    chk(req, 64'(buf_idx[b]), 64'(idx));
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    frm_valid = 1'b0; frm_id = '0; frm_rtr = 1'b0; frm_data = '0;
    buf_clr = 2'b00; ovf_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 full", 64'(buf_full), 64'd0);
    chk("R1 irq", 64'(rx_irq), 64'd0);
    chk("R1 err", 64'(ovf_err), 64'd0);
    // R1: zero masks let filter 0 accept anything
    send(11'h555, 1'b0, 2'b00);
    chk("R1 accept-all irq", 64'(rx_irq), 64'b01);
    chk_buf("R1 accept-all", 0, 11'h555, 1'b0, 3'd0);
    @(negedge clk);
    chk("R6 irq one cycle", 64'(rx_irq), 64'd0);
    release_bufs(2'b11, 1'b1);
    chk("R9 cleared", 64'(buf_full), 64'd0);

    // configuration: R2 layout, low-byte bits 4:0 set on filter 0 to show they are ignored
    wr(5'd0, 8'h24);  wr(5'd1, 8'h7F);   // filter 0 = 0x123
    wr(5'd2, 8'h8A);  wr(5'd3, 8'hC0);   // filter 1 = 0x456
    wr(5'd4, 8'h40);  wr(5'd5, 8'h00);   // filter 2 = 0x200
    wr(5'd6, 8'h7C);  wr(5'd7, 8'h00);   // filter 3 = 0x3E0
    wr(5'd8, 8'h24);  wr(5'd9, 8'h60);   // filter 4 = 0x123
    wr(5'd10, 8'hFC); wr(5'd11, 8'h00);  // filter 5 = 0x7E0
    wr(5'd12, 8'hFF); wr(5'd13, 8'hE0);  // mask 0: all bits
    wr(5'd14, 8'hFC); wr(5'd15, 8'h00);  // mask 1: upper six bits

    for (int v = 0; v < NV; v++) begin
      logic [10:0] id;
      logic [1:0]  eirq;
      id   = VEC[v][20:10];
      eirq = VEC[v][5:4];
      if (VEC[v][8:7] != 2'b00 || VEC[v][6]) release_bufs(VEC[v][8:7], VEC[v][6]);
      send(id, VEC[v][9], 2'b00);
      chk("R3 R4 R6 irq", 64'(rx_irq), 64'(eirq));
      chk("R7 err", 64'(ovf_err), 64'(VEC[v][0]));
      for (int b = 0; b < 2; b++)
        if (eirq[b]) chk_buf("R5 R6 contents", b, id, VEC[v][9], VEC[v][3:1]);
      if (v == 9) chk_buf("R7 unchanged", 0, 11'h123, 1'b0, 3'd0);
    end

    // R8: rollover on
    wr(5'd16, 8'h01);
    release_bufs(2'b11, 1'b1);
    send(11'h123, 1'b0, 2'b00);
    chk("R8 first to b0", 64'(rx_irq), 64'b01);
    send(11'h456, 1'b1, 2'b00);
    chk("R8 rollover irq", 64'(rx_irq), 64'b10);
    chk_buf("R8 rollover", 1, 11'h456, 1'b1, 3'd1);
    chk("R8 no err", 64'(ovf_err), 64'd0);
    send(11'h123, 1'b0, 2'b00);
    chk("R8 both full irq", 64'(rx_irq), 64'd0);
    chk("R7 R8 both full err", 64'(ovf_err), 64'd1);
    chk_buf("R7 b0 kept", 0, 11'h123, 1'b0, 3'd0);
    chk_buf("R7 b1 kept", 1, 11'h456, 1'b1, 3'd1);

    // R9: clear in the same cycle as a frame
    send(11'h456, 1'b0, 2'b01);
    chk("R9 same-cycle irq", 64'(rx_irq), 64'b01);
    chk_buf("R9 same-cycle", 0, 11'h456, 1'b0, 3'd1);
    chk("R9 full", 64'(buf_full), 64'b11);

    // R7: drop beats a simultaneous error clear
    @(negedge clk);
    frm_valid = 1'b1; frm_id = 11'h123; frm_data = pat(11'h123); ovf_clr = 1'b1;
    @(negedge clk);
    frm_valid = 1'b0; ovf_clr = 1'b0;
    chk("R7 set wins", 64'(ovf_err), 64'd1);
    release_bufs(2'b00, 1'b1);
    chk("R7 cleared", 64'(ovf_err), 64'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule